// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. Setting the start request makes it run through an optional pre-charge phase and an optional acquisition phase, each measured in instruction cycles of four system clocks. After a fixed start delay it opens an eleven-period conversion window. The first period of the window isolates the hold capacitor. The next ten periods each try one bit of the DAC code, from the most significant bit down, and keep or drop that bit according to an external comparator.

The length of one conversion period comes either from a divider on the system clock, chosen by a 3-bit select whose codes do not rise in order, or from pulses of a separate RC oscillator. Only the RC source may keep converting while the chip asks to sleep. The comparator, the DAC and the analog switches are outside the block. Control fields arrive as plain input ports. Completion loads the result, raises an interrupt flag and drops busy, all in the same cycle.

Top module: `sar_seq`

## Requirements
- R1: With the divided source, one conversion period (TAD) lasts 2, 4, 8, 16, 32 or 64 system clocks for `clk_sel_i` = 000, 100, 001, 101, 010, 110 respectively.
- R2: When `clk_sel_i[1:0]` = 11, each TAD ends on a `rc_tick_i` pulse, and the divider plays no part.
- R3: `precharge_o` is high for exactly 4 × `pre_cnt_i` clocks after the start. A count of 0 skips the phase and keeps `precharge_o` low.
- R4: `acquire_o` is high for exactly 4 × `acq_cnt_i` clocks right after pre-charge. A count of 0 skips the phase.
- R5: `busy_o` rises the clock after a `go_set_i` pulse in idle. `hold_open_o` rises 4 × (`pre_cnt_i` + `acq_cnt_i` + 1) clocks after `busy_o` rises. This includes a fixed 4-clock start delay.
- R6: `hold_open_o` stays high for the whole window of 11 TADs and only while busy. The first nonzero `dac_code_o` is 10'h200, so bit 9 is tried first.
- R7: One clock after the last TAD ends, `result_o` takes the resolved code, `irq_flag_o` sets and `busy_o` clears, all on the same edge. The resolved code is the largest value whose trial the comparator did not report as "input below DAC".
- R8: With a divided source, `sleep_i` high during a sequence aborts it on the next edge. With the RC source, `sleep_i` has no effect and the conversion completes.
- R9: A `go_clr_i` pulse during a sequence returns the block to idle on the next edge. `result_o` and `irq_flag_o` keep their values.
- R10: `irq_flag_o` stays set until a `flag_clr_i` pulse. A completion in the same cycle as the pulse wins.
- R11: After reset `busy_o`, `irq_flag_o`, `result_o`, `dac_code_o` and all phase outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_set_i | input | 1 | Pulse: request a conversion |
| go_clr_i | input | 1 | Pulse: cancel the running sequence |
| clk_sel_i | input | 3 | TAD source select |
| rc_tick_i | input | 1 | One-clock pulse from the RC oscillator |
| sleep_i | input | 1 | Sleep request |
| pre_cnt_i | input | 7 | Pre-charge length in instruction cycles |
| acq_cnt_i | input | 7 | Acquisition length in instruction cycles |
| cmp_below_i | input | 1 | Comparator: analog input below the DAC level |
| flag_clr_i | input | 1 | Pulse: clear the interrupt flag |
| busy_o | output | 1 | Start/busy bit |
| precharge_o | output | 1 | Pre-charge phase active |
| acquire_o | output | 1 | Acquisition phase active |
| hold_open_o | output | 1 | Hold capacitor isolated (conversion window) |
| dac_code_o | output | 10 | Trial code for the DAC |
| result_o | output | 10 | Last completed result |
| irq_flag_o | output | 1 | Conversion-complete flag |

## Verification
The hardest case to reach is a sleep request that arrives in the middle of a bit-decision window. The outcome depends on the clock source: a divided source must drop the partial code and leave the earlier result in place, while the RC source must carry on. The bench first completes a conversion so that a known result and a cleared flag are in place. It then starts a second conversion with a different analog value, waits a computed number of clocks until the window is open, and raises sleep. It repeats the case with the RC source and sleep held high for the whole run. A full sweep of all 1024 input levels at the fastest divider, together with sweeps over every divided select and several phase counts, checks the resolved code and each phase length against closed-form cycle counts.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACQ,
        ST_DLY,
        ST_CONV,
        ST_DONE
    } seq_state_t;

    // the RC oscillator drives the conversion period when both low select bits are set
    function automatic logic sel_is_rc(input logic [2:0] sel);
        return sel[1] & sel[0];
    endfunction

    // log2 of the divide ratio; the select bits are rotated so the codes rank in order
    function automatic logic [3:0] sel_log2(input logic [2:0] sel);
        return 4'd1 + {1'b0, sel[1:0], sel[2]};
    endfunction

endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen
    import sar_seq_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [2:0] sel_i,
    input  logic       rc_tick_i,
    output logic       tad_end_o
);
    localparam int PER_W = DIV_W + 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [PER_W-1:0] period, limit;
    logic             rc_mode;

    always_comb begin
        rc_mode   = sel_is_rc(sel_i);
        period    = PER_W'(1) << sel_log2(sel_i);
        limit     = period - PER_W'(1);
        tad_end_o = run_i && (rc_mode ? rc_tick_i : ({1'b0, div_q} >= limit));
        div_d     = (!run_i || rc_mode || tad_end_o) ? '0 : div_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // a divided period never ends earlier than two clocks after the window opens
    assert_div_min_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !rc_mode && tad_end_o) |=> !tad_end_o);

endmodule

// File: rtl/sar_bits.sv
module sar_bits #(
    parameter int RES  = 10,
    parameter int TI_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            step_i,
    input  logic [TI_W-1:0] idx_i,
    input  logic            cmp_below_i,
    output logic [RES-1:0]  code_o
);
    logic [RES-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (clear_i) begin
            code_d = '0;
        end else if (step_i) begin
            for (int i = 0; i < RES; i++) begin
                // the bit tried in this period is dropped when the input is below
                if ((int'(idx_i) == RES - i) && cmp_below_i) code_d[i] = 1'b0;
                // the next lower bit is tried in the following period
                if (int'(idx_i) == RES - 1 - i) code_d[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assign code_o = code_q;

    assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && idx_i == '0) |=> (code_q == (RES'(1) << (RES - 1))));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int CNT_W    = 7,
    parameter int ICYC     = 4,
    parameter int DIV_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_set_i,
    input  logic                go_clr_i,
    input  logic [2:0]          clk_sel_i,
    input  logic                rc_tick_i,
    input  logic                sleep_i,
    input  logic [CNT_W-1:0]    pre_cnt_i,
    input  logic [CNT_W-1:0]    acq_cnt_i,
    input  logic                cmp_below_i,
    input  logic                flag_clr_i,
    output logic                busy_o,
    output logic                precharge_o,
    output logic                acquire_o,
    output logic                hold_open_o,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                irq_flag_o
);
    localparam int PH_W = $clog2(((2 ** CNT_W) - 1) * ICYC);
    localparam int TADS = RES_BITS + 1;
    localparam int TI_W = $clog2(TADS + 1);

    typedef struct packed {
        seq_state_t          st;
        logic [PH_W-1:0]     cnt;
        logic [TI_W-1:0]     tad;
        logic                busy;
        logic                flag;
        logic [RES_BITS-1:0] result;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      tad_end, rc_mode, abort, bits_clear;

    function automatic logic [PH_W-1:0] phase_load(input logic [CNT_W-1:0] n);
        return PH_W'(n) * PH_W'(ICYC) - PH_W'(1);
    endfunction

    sar_tad_gen #(.DIV_W(DIV_W)) tad_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (r_q.st == ST_CONV),
        .sel_i     (clk_sel_i),
        .rc_tick_i (rc_tick_i),
        .tad_end_o (tad_end)
    );

    assign bits_clear = (r_q.st != ST_CONV) && (r_q.st != ST_DONE);

    sar_bits #(.RES(RES_BITS), .TI_W(TI_W)) bits_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (bits_clear),
        .step_i      (tad_end),
        .idx_i       (r_q.tad),
        .cmp_below_i (cmp_below_i),
        .code_o      (dac_code_o)
    );

    always_comb begin
        r_d     = r_q;
        rc_mode = sel_is_rc(clk_sel_i);
        abort   = go_clr_i || (sleep_i && !rc_mode);

        unique case (r_q.st)
            ST_IDLE: begin
                if (go_set_i) begin
                    r_d.busy = 1'b1;
                    if (pre_cnt_i != '0) begin
                        r_d.st  = ST_PRE;
                        r_d.cnt = phase_load(pre_cnt_i);
                    end else if (acq_cnt_i != '0) begin
                        r_d.st  = ST_ACQ;
                        r_d.cnt = phase_load(acq_cnt_i);
                    end else begin
                        r_d.st  = ST_DLY;
                        r_d.cnt = PH_W'(ICYC - 1);
                    end
                end
            end
            ST_PRE: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - PH_W'(1);
                end else if (acq_cnt_i != '0) begin
                    r_d.st  = ST_ACQ;
                    r_d.cnt = phase_load(acq_cnt_i);
                end else begin
                    r_d.st  = ST_DLY;
                    r_d.cnt = PH_W'(ICYC - 1);
                end
            end
            ST_ACQ: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - PH_W'(1);
                end else begin
                    r_d.st  = ST_DLY;
                    r_d.cnt = PH_W'(ICYC - 1);
                end
            end
            ST_DLY: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - PH_W'(1);
                end else begin
                    r_d.st  = ST_CONV;
                    r_d.tad = '0;
                end
            end
            ST_CONV: begin
                if (tad_end) begin
                    if (int'(r_q.tad) == TADS - 1) r_d.st = ST_DONE;
                    else                           r_d.tad = r_q.tad + TI_W'(1);
                end
            end
            ST_DONE: begin
                r_d.st     = ST_IDLE;
                r_d.busy   = 1'b0;
                r_d.flag   = 1'b1;
                r_d.result = dac_code_o;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (abort && r_q.st != ST_DONE) begin
            r_d.st   = ST_IDLE;
            r_d.busy = 1'b0;
        end

        if (flag_clr_i && r_q.st != ST_DONE) r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.cnt    <= '0;
            r_q.tad    <= '0;
            r_q.busy   <= 1'b0;
            r_q.flag   <= 1'b0;
            r_q.result <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = r_q.busy;
    assign precharge_o = (r_q.st == ST_PRE);
    assign acquire_o   = (r_q.st == ST_ACQ);
    assign hold_open_o = (r_q.st == ST_CONV);
    assign result_o    = r_q.result;
    assign irq_flag_o  = r_q.flag;

    assert_done_actions_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE) |=> (irq_flag_o && !busy_o && result_o == $past(dac_code_o)));

    assert_clr_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (go_clr_i && busy_o && r_q.st != ST_DONE) |=> (!busy_o && $stable(result_o)));

    assert_sleep_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !rc_mode && busy_o && r_q.st != ST_DONE) |=> !busy_o);

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !flag_clr_i) |=> irq_flag_o);

    assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({precharge_o, acquire_o, hold_open_o}));

    assert_pre_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && go_set_i && pre_cnt_i == '0 && !abort) |=> !precharge_o);

    assert_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_open_o |-> busy_o);

endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_set = 1'b0, go_clr = 1'b0, sleep = 1'b0, flag_clr = 1'b0;
    logic [2:0] sel = 3'b000;
    logic       rc_tick = 1'b0;
    logic [6:0] pre = '0, acq = '0;
    logic [9:0] vin = '0;
    logic       cmp_below;
    logic       busy, prech, acqo, hold, irq;
    logic [9:0] dac, result;
    int         total = 0, bad = 0;
    int         rc_div = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        rc_div  <= (rc_div == 2) ? 0 : rc_div + 1;
        rc_tick <= (rc_div == 2);
    end

    assign cmp_below = (vin < dac);

    sar_seq dut_i (
        .clk(clk), .rst_n(rst_n), .go_set_i(go_set), .go_clr_i(go_clr),
        .clk_sel_i(sel), .rc_tick_i(rc_tick), .sleep_i(sleep),
        .pre_cnt_i(pre), .acq_cnt_i(acq), .cmp_below_i(cmp_below),
        .flag_clr_i(flag_clr), .busy_o(busy), .precharge_o(prech),
        .acquire_o(acqo), .hold_open_o(hold), .dac_code_o(dac),
        .result_o(result), .irq_flag_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int div_of(input logic [2:0] s);
        case (s)
            3'b000: return 2;
            3'b100: return 4;
            3'b001: return 8;
            3'b101: return 16;
            3'b010: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    // runs one conversion; timing checks apply to the divided sources
    task automatic convert(input logic [2:0] s, input int p, input int a,
                           input int v, input bit timing);
        int n_busy = 0, n_pre = 0, n_acq = 0, n_hold = 0, lead = -1, first_dac = -1;
        int n = div_of(s);
        clear_flag();
        @(negedge clk);
        sel = s; pre = 7'(p); acq = 7'(a); vin = 10'(v); go_set = 1'b1;
        @(negedge clk) go_set = 1'b0;
        for (int guard = 0; guard < 4000 && busy; guard++) begin
            n_busy++;
            if (prech) n_pre++;
            if (acqo)  n_acq++;
            if (hold) begin
                n_hold++;
                if (lead < 0) lead = n_busy - 1;
            end
            if (dac != 0 && first_dac < 0) first_dac = int'(dac);
            @(negedge clk);
        end
        chk("R7 result", int'(result), v);
        chk("R7 flag", int'(irq), 1);
        chk("R6 first trial", first_dac, 512);
        if (timing) begin
            chk("R3 precharge length", n_pre, 4 * p);
            chk("R4 acquire length", n_acq, 4 * a);
            chk("R5 lead to window", lead, 4 * (p + a + 1));
            chk("R1 window length", n_hold, 11 * n);
            chk("R5 busy length", n_busy, 4 * (p + a + 1) + 11 * n + 1);
        end else begin
            // R2: three-clock RC period; the window start is not aligned to it
            chk("R2 window in range", int'(n_hold >= 31 && n_hold <= 33), 1);
        end
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog actual=expired expected=finish");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", int'(busy), 0);
        chk("R11 result", int'(result), 0);
        chk("R11 flag", int'(irq), 0);
        chk("R11 dac", int'(dac), 0);
        chk("R11 phases", int'({prech, acqo, hold}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: every input level at the fastest divider
        for (int v = 0; v < 1024; v++) convert(3'b000, 0, 0, v, 1'b1);

        // R1 R3 R4: each divided select with several phase counts
        for (int k = 0; k < 6; k++) begin
            logic [2:0] s;
            case (k)
                0: s = 3'b000; 1: s = 3'b100; 2: s = 3'b001;
                3: s = 3'b101; 4: s = 3'b010; default: s = 3'b110;
            endcase
            convert(s, 0, 0, 1023 - 37 * k, 1'b1);
            convert(s, 1, 0, 5 + 101 * k, 1'b1);
            convert(s, 0, 3, 511 + k, 1'b1);
            convert(s, 2, 5, 170 * k, 1'b1);
        end

        // R2: RC source, both x11 codes
        convert(3'b011, 0, 0, 341, 1'b0);
        convert(3'b111, 1, 1, 682, 1'b0);

        // R10: flag holds without clear, drops on clear
        convert(3'b000, 0, 0, 300, 1'b1);
        repeat (5) @(negedge clk);
        chk("R10 flag held", int'(irq), 1);
        clear_flag();
        chk("R10 flag cleared", int'(irq), 0);

        // R8: sleep in the middle of a divided window aborts
        @(negedge clk);
        sel = 3'b101; pre = '0; acq = '0; vin = 10'd700; go_set = 1'b1;
        @(negedge clk) go_set = 1'b0;
        repeat (40) @(negedge clk);
        chk("R8 window open before sleep", int'(hold), 1);
        sleep = 1'b1;
        @(negedge clk);
        chk("R8 busy dropped", int'(busy), 0);
        chk("R8 result kept", int'(result), 300);
        chk("R8 flag untouched", int'(irq), 0);
        sleep = 1'b0;

        // R8: RC source keeps converting while asleep
        sleep = 1'b1;
        convert(3'b011, 0, 0, 777, 1'b0);
        sleep = 1'b0;

        // R9: cancel during pre-charge keeps result and flag
        @(negedge clk);
        sel = 3'b000; pre = 7'd10; acq = '0; vin = 10'd5; go_set = 1'b1;
        @(negedge clk) go_set = 1'b0;
        repeat (5) @(negedge clk);
        go_clr = 1'b1;
        @(negedge clk) go_clr = 1'b0;
        chk("R9 busy dropped", int'(busy), 0);
        chk("R9 phase stopped", int'(prech), 0);
        chk("R9 result kept", int'(result), 777);
        chk("R9 flag kept", int'(irq), 1);
        repeat (60) @(negedge clk);
        chk("R9 stays idle", int'(busy), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule